// File: doc/BRIEF.md
# Supply-Pulse Trim Programming Decoder

This block sits inside a field-trimmable sensor. It turns a programming stream, sent as voltage levels on the supply pin, into a trim code. An external comparator bank has already reduced the supply voltage to one of four symbols, and those symbols arrive on `lvl`. The decoder measures each symbol run in sample-clock cycles. It discards runs that are too short to be real pulses. It then interprets the stream as sequences: a short high pulse opens a sequence, mid pulses count an address, and a high pulse of at least the blow length may end the sequence as a burn command.

The block keeps two kinds of trim state. A provisional register follows the address count of the open sequence directly. It holds its value only while the supply stays above the zero level, so candidate codes can be tried and discarded. Five permanent fuse bits are each burnt by a sequence whose address count equals that bit's weight, followed by a long high pulse. A sixth, device-wide lock fuse is burnt with a reserved address count. Once locked, the block ignores all further programming and drives the fuse bits alone as the trim code.

Top module: `trim_prog_decoder`

## Requirements
- R1: While reset is held and immediately after it, `trim`, `blow_stb`, `lock_stb`, `locked` and `cmd_err` are all zero.
- R2: The `lvl` encoding is 0 = zero, 1 = low, 2 = mid, 3 = high. After a short high pulse, followed by N valid mid pulses with low gaps (1 ≤ N ≤ 31), an unlocked block with no fuses blown shows `trim` = N. If more than 31 mid pulses arrive, `trim` stays at 31.
- R3: One sample of level zero clears the provisional register and closes any open sequence, so `trim` equals the fuse bits on the next cycle. Blown fuses survive the zero level.
- R4: A mid or high run shorter than MIN_PULSE samples is ignored. A short mid run does not advance the count. A short high run neither restarts the sequence nor burns anything.
- R5: If a low run between pulses is shorter than MIN_GAP samples, the open sequence is dropped. Mid pulses that follow it are not counted until a new opening high pulse arrives.
- R6: Mid pulses that arrive while no sequence is open have no effect on `trim`.
- R7: A high run of at least BLOW_LEN samples ends a sequence whose count is 2^k (k < 5). When the high run ends, `blow_stb` bit k pulses for exactly one cycle and fuse bit k is set for good.
- R8: If the count is neither a power of two below 32 nor LOCK_ADDR, the long high pulse raises `cmd_err` for one cycle and changes no fuse.
- R9: A count equal to LOCK_ADDR (default 32) followed by a long high pulse pulses `lock_stb` for one cycle and sets `locked`. `locked` then never clears, not even through the zero level.
- R10: While `locked` is 1, `trim` equals the fuse bits. No sequence then changes `trim`, and none produces `blow_stb`, `lock_stb` or `cmd_err`.
- R11: While unlocked, `trim` is the bitwise OR of the fuse bits and the provisional register.
- R12: A high run of at least MIN_PULSE but fewer than BLOW_LEN samples opens a fresh sequence with count zero, even if it ends an address group. A run of exactly BLOW_LEN−1 samples is still short.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low reset; returns fuses to the unburnt state |
| lvl | input | 2 | Quantized supply symbol: 0 zero, 1 low, 2 mid, 3 high |
| trim | output | 5 | Effective trim code |
| blow_stb | output | 5 | One-cycle one-hot strobe naming the fuse bit being burnt |
| lock_stb | output | 1 | One-cycle strobe when the lock fuse is burnt |
| locked | output | 1 | Lock fuse state |
| cmd_err | output | 1 | One-cycle flag for a rejected burn command |

## Verification
The bench sweeps every provisional count from 1 to 31 and every burn count from 1 to 31. It does not burn count 16, because that value is kept as the probe for lock blocking. A decoder that mis-decodes powers of two would burn a wrong bit or miss a rejection. The bench probes pulse lengths one sample either side of MIN_PULSE and BLOW_LEN. A high pulse of BLOW_LEN−1 samples after a count of two must open a new sequence and burn nothing. An off-by-one run counter would instead burn bit 1. Other corner cases are a glitch high between address pulses, a short gap after the opening pulse, and mid pulses before any opening pulse. A design that got any of these wrong would show a wrong `trim` after the next address group. After locking, a count of 16 must leave `trim` at the burnt fuse value. A lock that only gated the burn path would show bit 4 set.

// File: rtl/trim_prog_decoder.sv
module trim_prog_decoder #(
  parameter int TRIM_W    = 5,
  parameter int CNT_W     = 6,
  parameter int MIN_PULSE = 20,
  parameter int MIN_GAP   = 20,
  parameter int BLOW_LEN  = 100,
  parameter int LOCK_ADDR = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        lvl,
  output logic [TRIM_W-1:0] trim,
  output logic [TRIM_W-1:0] blow_stb,
  output logic              lock_stb,
  output logic              locked,
  output logic              cmd_err
);
  localparam int LONGEST  = (BLOW_LEN > MIN_PULSE) ? ((BLOW_LEN > MIN_GAP) ? BLOW_LEN : MIN_GAP)
                                                   : ((MIN_PULSE > MIN_GAP) ? MIN_PULSE : MIN_GAP);
  localparam int RUN_W    = $clog2(LONGEST + 1);
  localparam int TRIM_MAX = (1 << TRIM_W) - 1;
  localparam logic [RUN_W-1:0] RUN_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  localparam logic [1:0] SYM_ZERO = 2'd0;
  localparam logic [1:0] SYM_LOW  = 2'd1;
  localparam logic [1:0] SYM_MID  = 2'd2;
  localparam logic [1:0] SYM_HIGH = 2'd3;

  logic [1:0]        lvl_q;
  logic [RUN_W-1:0]  run_len;
  logic              en;
  logic [CNT_W-1:0]  cnt;
  logic [TRIM_W-1:0] prov;
  logic [TRIM_W-1:0] fuse;

  wire ended     = (lvl != lvl_q);
  wire real_run  = (run_len >= RUN_W'(MIN_PULSE));
  wire long_run  = (run_len >= RUN_W'(BLOW_LEN));
  wire mid_done  = ended && (lvl_q == SYM_MID)  && real_run;
  wire high_done = ended && (lvl_q == SYM_HIGH) && real_run;
  wire gap_short = ended && (lvl_q == SYM_LOW)  && (run_len < RUN_W'(MIN_GAP));

  wire [CNT_W-1:0] cnt_inc = (cnt == CNT_MAX) ? cnt : cnt + CNT_W'(1);
  wire cnt_pow2  = (cnt != '0) && ((cnt & (cnt - CNT_W'(1))) == '0);
  wire cnt_lock  = (cnt == CNT_W'(LOCK_ADDR));
  wire cnt_bit   = cnt_pow2 && (cnt <= CNT_W'(TRIM_MAX));
  wire burn      = high_done && long_run && en && (cnt != '0) && !locked;
  wire clear_seq = (lvl == SYM_ZERO) || locked || gap_short;

  assign trim = locked ? fuse : (fuse | prov);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q    <= SYM_ZERO;
      run_len  <= '0;
      en       <= 1'b0;
      cnt      <= '0;
      prov     <= '0;
      fuse     <= '0;
      locked   <= 1'b0;
      blow_stb <= '0;
      lock_stb <= 1'b0;
      cmd_err  <= 1'b0;
    end else begin
      lvl_q    <= lvl;
      run_len  <= ended ? RUN_W'(1) : ((run_len == RUN_MAX) ? run_len : run_len + RUN_W'(1));
      blow_stb <= '0;
      lock_stb <= 1'b0;
      cmd_err  <= 1'b0;

      if (burn) begin
        if (cnt_lock) begin
          locked   <= 1'b1;
          lock_stb <= 1'b1;
        end else if (cnt_bit) begin
          fuse     <= fuse | cnt[TRIM_W-1:0];
          blow_stb <= cnt[TRIM_W-1:0];
        end else begin
          cmd_err  <= 1'b1;
        end
      end

      if (clear_seq) begin
        en  <= 1'b0;
        cnt <= '0;
      end else if (high_done) begin
        en  <= !long_run;
        cnt <= '0;
      end else if (mid_done && en) begin
        cnt <= cnt_inc;
      end

      if ((lvl == SYM_ZERO) || locked || (burn && cnt_lock))
        prov <= '0;
      else if (mid_done && en && !gap_short && (cnt_inc <= CNT_W'(TRIM_MAX)))
        prov <= cnt_inc[TRIM_W-1:0];
    end
  end
endmodule

module trim_prog_decoder_chk #(
  parameter int TRIM_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        lvl,
  input logic [TRIM_W-1:0] trim,
  input logic [TRIM_W-1:0] blow_stb,
  input logic [TRIM_W-1:0] fuse,
  input logic              lock_stb,
  input logic              locked,
  input logic              cmd_err
);
  assert_strobe_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(blow_stb));

  assert_fuse_never_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((fuse & $past(fuse)) == $past(fuse)));

  assert_reject_burns_nothing_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |-> (blow_stb == '0 && !lock_stb));

  assert_lock_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);

  assert_locked_inert_R10: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> (blow_stb == '0 && !lock_stb && !cmd_err && $stable(trim)));

  assert_zero_drops_provisional_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl == 2'd0) |=> (trim == fuse));

  assert_trim_covers_fuse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ((trim & fuse) == fuse));
endmodule

bind trim_prog_decoder trim_prog_decoder_chk #(.TRIM_W(TRIM_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lvl(lvl), .trim(trim), .blow_stb(blow_stb),
  .fuse(fuse), .lock_stb(lock_stb), .locked(locked), .cmd_err(cmd_err)
);

// File: tb/trim_prog_decoder_test.sv
module trim_prog_decoder_test;
  localparam int MP = 20;
  localparam int MG = 20;
  localparam int BL = 100;
  localparam int LOCK = 32;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] lvl = 2'd0;
  logic [4:0] trim, blow_stb;
  logic       lock_stb, locked, cmd_err;
  int vectors = 0;
  int misses = 0;
  bit done = 1'b0;
  int fuse_m = 0;

  always #5 clk = ~clk;

  trim_prog_decoder uut (
    .clk(clk), .rst_n(rst_n), .lvl(lvl), .trim(trim), .blow_stb(blow_stb),
    .lock_stb(lock_stb), .locked(locked), .cmd_err(cmd_err)
  );

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic hold(input logic [1:0] v, input int n);
    lvl = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic zero();
    hold(2'd0, 3);
    hold(2'd1, MG);
  endtask

  task automatic open_seq();
    hold(2'd3, MP);
    hold(2'd1, MG);
  endtask

  task automatic mids(input int n);
    for (int i = 0; i < n; i++) begin
      hold(2'd2, MP);
      hold(2'd1, MG);
    end
  endtask

  task automatic burn(input int hi_len, output int stb, output int lk, output int er);
    hold(2'd3, hi_len);
    hold(2'd1, 1);
    stb = blow_stb;
    lk = lock_stb;
    er = cmd_err;
    hold(2'd1, MG);
  endtask

  function automatic bit is_bit(input int c);
    return (c > 0) && (c < 32) && ((c & (c - 1)) == 0);
  endfunction

  initial begin
    int stb, lk, er;
    repeat (3) @(negedge clk);
    check("R1 trim", trim, 0);
    check("R1 locked", locked, 0);
    check("R1 strobes", {lock_stb, cmd_err, blow_stb}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {locked, trim}, 0);
    hold(2'd1, MG);

    for (int n = 1; n <= 31; n++) begin
      zero();
      open_seq();
      mids(n);
      check("R2 provisional count", trim, n);
      hold(2'd0, 1);
      check("R3 zero clears", trim, 0);
      hold(2'd1, MG);
    end
    zero(); open_seq(); mids(34);
    check("R2 saturation", trim, 31);

    zero(); open_seq(); mids(3);
    hold(2'd2, MP - 1); hold(2'd1, MG);
    check("R4 short mid ignored", trim, 3);
    hold(2'd3, MP - 1); hold(2'd1, MG);
    mids(1);
    check("R4 short high ignored", trim, 4);
    hold(2'd3, MP); hold(2'd1, MG);
    mids(2);
    check("R12 restart at MIN_PULSE", trim, 2);
    burn(BL - 1, stb, lk, er);
    check("R12 BLOW_LEN-1 burns nothing", stb + lk + er, 0);
    mids(1);
    check("R12 restart after near-long high", trim, 1);

    zero(); mids(4);
    check("R6 mids without opening", trim, 0);
    zero(); hold(2'd3, MP); hold(2'd1, MG - 1); mids(2);
    check("R5 short gap drops sequence", trim, 0);

    zero(); open_seq(); mids(2);
    burn(BL, stb, lk, er);
    check("R7 strobe bit1", stb, 2);
    check("R7 no error", er, 0);
    fuse_m = 2;
    zero();
    check("R7 fuse survives zero", trim, 2);
    open_seq(); mids(8);
    burn(BL, stb, lk, er);
    check("R7 strobe bit3", stb, 8);
    fuse_m = 10;
    zero(); open_seq(); mids(5);
    check("R11 fuse OR provisional", trim, 15);
    zero();
    check("R11 fuse only after zero", trim, 10);

    for (int c = 1; c <= 31; c++) begin
      if (c == 16) continue;
      zero(); open_seq(); mids(c);
      burn(BL, stb, lk, er);
      check("R7 sweep strobe", stb, is_bit(c) ? c : 0);
      check("R8 sweep error", er, is_bit(c) ? 0 : 1);
      check("R8 sweep no lock", lk, 0);
      if (is_bit(c)) fuse_m = fuse_m | c;
      zero();
      check("R8 sweep fuses", trim, fuse_m);
    end

    zero(); open_seq(); mids(LOCK);
    burn(BL, stb, lk, er);
    check("R9 lock strobe", lk, 1);
    check("R9 lock no bit strobe", stb + er, 0);
    check("R9 locked", locked, 1);
    zero();
    check("R9 lock survives zero", locked, 1);
    open_seq(); mids(16);
    check("R10 locked ignores provisional", trim, fuse_m);
    burn(BL, stb, lk, er);
    check("R10 locked burns nothing", stb + lk + er, 0);
    zero();
    check("R10 trim equals fuses", trim, 15);

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      vectors++;
      misses++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end
endmodule